// File: doc/BRIEF.md
# Cross-Domain Lookup Table Loader

This block holds a 64-word by 32-bit lookup table. Logic on a slow clock loads the table, and logic on a fast clock reads it. The fast side reads with zero latency: the output is a combinational function of the lookup address. The slow side never touches the table storage directly. Each update enters a shallow asynchronous FIFO as one 38-bit entry that holds a 6-bit address and a 32-bit word. A drain stage on the fast clock takes out one entry per cycle while the FIFO holds any, and writes it into the table. The table therefore has only one clock and no dual-clock ports.

The slow side also drives a load-complete level. This level crosses into the fast domain through a two-flop synchroniser. The fast side raises a registered lookup-valid flag when two things hold: the synchronised level is high, and no update is waiting in the FIFO. Consumers of the table wait for that flag before they trust the contents. Each domain has its own active-high synchronous reset. That reset clears only the pointers and flags of its own domain.

Top module: `lutx_loader`

## Requirements
- R1: `lk_data` equals the table word stored at `lk_addr` in the same fast cycle, with no register between address and data.
- R2: An update is accepted on a `slow_clk` rising edge when `wr_valid` and `wr_ready` are both high. Once drained, `wr_data` is stored at table address `wr_addr`, and every one of the 64 addresses is writable.
- R3: While a domain is in reset and on the cycle after it leaves reset, that domain's flags hold their idle values: `wr_ready` is 1 and `lk_valid` is 0.
- R4: The FIFO write and read pointers cross domains as Gray codes. Each pointer changes by exactly one bit whenever it changes.
- R5: The FIFO holds 4 pending updates. With 4 pending, `wr_ready` is low and a held `wr_valid` is not accepted. The held update is accepted later and is not lost. Updates reach the table in the order they were accepted, so the last write to an address wins.
- R6: `lk_valid` is high only when `load_en`, after synchronisation, is high and the FIFO is empty. It falls within a few fast cycles after `load_en` falls.
- R7: When a drain write and a lookup hit the same address in the same fast cycle, `lk_data` shows the old word in that cycle and the new word from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Loader clock |
| slow_rst | input | 1 | Active-high synchronous reset, loader domain |
| wr_valid | input | 1 | Update request |
| wr_ready | output | 1 | FIFO can accept an update |
| wr_addr | input | 6 | Table address of the update |
| wr_data | input | 32 | Word to store |
| load_en | input | 1 | Table contents are complete (level) |
| fast_clk | input | 1 | Lookup clock |
| fast_rst | input | 1 | Active-high synchronous reset, lookup domain |
| lk_addr | input | 6 | Lookup address |
| lk_data | output | 32 | Table word at `lk_addr`, zero latency |
| lk_valid | output | 1 | Table is enabled and no update is pending |

## Verification
A drain write and a lookup can fall in the same fast cycle. When they target the same entry, the read must return the word from before the write. The bench provokes this by holding `lk_addr` on one entry while the slow side sends a new word for that same entry. It samples `lk_data` on every fast cycle while the update crosses. The judgement is that only the old word and then the new word appear, with exactly one change between them, and the trace ends on the new word. An embedded property checks, cycle by cycle, that the new word appears on the cycle after the colliding write.

// File: rtl/lutx_pkg.sv
`timescale 1ns/1ps
package lutx_pkg;
  localparam int unsigned LUT_AW  = 6;
  localparam int unsigned LUT_DW  = 32;
  localparam int unsigned FIFO_AW = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lutx_sync.sv
`timescale 1ns/1ps
module lutx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = lutx_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lutx_pair_fifo.sv
`timescale 1ns/1ps
module lutx_pair_fifo #(
  parameter int unsigned W  = 38,
  parameter int unsigned AW = lutx_pkg::FIFO_AW
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         rclk,
  input  logic         rrst,
  output logic         pop_valid,
  input  logic         pop,
  output logic [W-1:0] pop_data
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_n, rbin_n;
  logic          full, empty, do_push, do_pop;

  // write domain
  assign full       = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign push_ready = ~full;
  assign do_push    = push_valid & ~full;
  assign wbin_n     = wbin + PW'(do_push);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (do_push) store[wbin[AW-1:0]] <= push_data;
  end

  lutx_sync #(.W(PW)) u_rptr_sync (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
  );

  // read domain
  assign empty     = (rgray == wgray_r);
  assign pop_valid = ~empty;
  assign do_pop    = pop & ~empty;
  assign rbin_n    = rbin + PW'(do_pop);
  assign pop_data  = store[rbin[AW-1:0]];

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  lutx_sync #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
  );

  // checker helpers: write-side view of occupancy
  logic [PW-1:0] rbin_w;
  logic [PW-1:0] wlevel;
  always_comb begin
    rbin_w[PW-1] = rgray_w[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_w[i] = rbin_w[i+1] ^ rgray_w[i];
  end
  assign wlevel = wbin - rbin_w;

  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (wrst)
    !$stable(wgray) |-> $countones(wgray ^ $past(wgray)) == 1); // R4
  AST_RGRAY_ONE_STEP: assert property (@(posedge rclk) disable iff (rrst)
    !$stable(rgray) |-> $countones(rgray ^ $past(rgray)) == 1); // R4
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (wrst)
    wlevel <= PW'(DEPTH)); // R5
  AST_HOLD_WHEN_FULL: assert property (@(posedge wclk) disable iff (wrst)
    (push_valid && !push_ready) |=> wbin == $past(wbin)); // R5
endmodule

// File: rtl/lutx_table.sv
`timescale 1ns/1ps
module lutx_table #(
  parameter int unsigned AW = lutx_pkg::LUT_AW,
  parameter int unsigned DW = lutx_pkg::LUT_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  AST_COLLIDE_NEW_NEXT: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == raddr) |=> (raddr != $past(raddr)) || (rdata == $past(wdata))); // R7
endmodule

// File: rtl/lutx_loader.sv
`timescale 1ns/1ps
module lutx_loader #(
  parameter int unsigned AW      = lutx_pkg::LUT_AW,
  parameter int unsigned DW      = lutx_pkg::LUT_DW,
  parameter int unsigned FIFO_AW = lutx_pkg::FIFO_AW
) (
  input  logic          slow_clk,
  input  logic          slow_rst,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_en,
  input  logic          fast_clk,
  input  logic          fast_rst,
  input  logic [AW-1:0] lk_addr,
  output logic [DW-1:0] lk_data,
  output logic          lk_valid
);
  localparam int unsigned EW = AW + DW;

  logic          drain_valid;
  logic [EW-1:0] drain_entry;
  logic          drain_we;
  logic          en_sync;
  logic          lk_valid_q;

  lutx_pair_fifo #(.W(EW), .AW(FIFO_AW)) u_fifo (
    .wclk      (slow_clk),
    .wrst      (slow_rst),
    .push_valid(wr_valid),
    .push_ready(wr_ready),
    .push_data ({wr_addr, wr_data}),
    .rclk      (fast_clk),
    .rrst      (fast_rst),
    .pop_valid (drain_valid),
    .pop       (drain_we),
    .pop_data  (drain_entry)
  );

  assign drain_we = drain_valid & ~fast_rst;

  lutx_table #(.AW(AW), .DW(DW)) u_table (
    .clk  (fast_clk),
    .rst  (fast_rst),
    .we   (drain_we),
    .waddr(drain_entry[EW-1:DW]),
    .wdata(drain_entry[DW-1:0]),
    .raddr(lk_addr),
    .rdata(lk_data)
  );

  lutx_sync #(.W(1)) u_en_sync (
    .clk(fast_clk), .rst(fast_rst), .d(load_en), .q(en_sync)
  );

  always_ff @(posedge fast_clk) begin
    if (fast_rst) lk_valid_q <= 1'b0;
    else          lk_valid_q <= en_sync & ~drain_valid;
  end

  assign lk_valid = lk_valid_q;

  AST_VALID_NEEDS_ENABLE: assert property (@(posedge fast_clk) disable iff (fast_rst)
    lk_valid |-> $past(en_sync)); // R6
  AST_VALID_AFTER_RESET: assert property (@(posedge fast_clk)
    $past(fast_rst) |-> !lk_valid); // R3
endmodule

// File: tb/lutx_loader_tb.sv
`timescale 1ns/1ps
module lutx_loader_tb_top;
  logic        slow_clk = 1'b0, fast_clk = 1'b0;
  logic        slow_rst = 1'b1, fast_rst = 1'b1;
  logic        wr_valid = 1'b0, load_en = 1'b0;
  logic        wr_ready, lk_valid;
  logic [5:0]  wr_addr = '0, lk_addr = '0;
  logic [31:0] wr_data = '0, lk_data;

  int checks = 0, fails = 0;
  logic [31:0] expv [64];
  bit done = 0;

  always #2.5 fast_clk = ~fast_clk;   // 200 MHz
  always #7   slow_clk = ~slow_clk;

  lutx_loader dut_i (
    .slow_clk(slow_clk), .slow_rst(slow_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_en(load_en),
    .fast_clk(fast_clk), .fast_rst(fast_rst), .lk_addr(lk_addr),
    .lk_data(lk_data), .lk_valid(lk_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic slow_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge slow_clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge slow_clk);
    @(posedge slow_clk); #1;
    wr_valid = 1'b0;
    expv[a] = d;
  endtask

  function automatic logic [31:0] pattern(input int i);
    return (32'(i) * 32'h0101_0107) ^ 32'h5A00_C300;
  endfunction

  initial begin
    #750000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge slow_clk);
    check("R3 wr_ready in reset", 32'(wr_ready), 32'd1);
    check("R3 lk_valid in reset", 32'(lk_valid), 32'd0);
    slow_rst = 1'b0; fast_rst = 1'b0;
    @(negedge fast_clk);
    check("R3 lk_valid after reset", 32'(lk_valid), 32'd0);

    // R2: load every address
    for (int i = 0; i < 64; i++) slow_write(6'(i), pattern(i));
    repeat (20) @(negedge fast_clk);
    check("R6 lk_valid low without load_en", 32'(lk_valid), 32'd0);

    // R5: fill while the fast side is held in reset
    @(negedge slow_clk); slow_rst = 1'b1; fast_rst = 1'b1;
    repeat (3) @(negedge slow_clk); slow_rst = 1'b0;
    slow_write(6'd10, 32'hAAAA_0001);
    slow_write(6'd11, 32'hAAAA_0002);
    slow_write(6'd12, 32'hAAAA_0003);
    slow_write(6'd10, 32'hAAAA_0004);
    @(negedge slow_clk);
    wr_valid = 1'b1; wr_addr = 6'd10; wr_data = 32'hAAAA_0005;
    for (int k = 0; k < 3; k++) begin
      @(negedge slow_clk);
      check("R5 wr_ready low when four pending", 32'(wr_ready), 32'd0);
    end
    @(negedge fast_clk); fast_rst = 1'b0;
    while (!wr_ready) @(negedge slow_clk);
    @(posedge slow_clk); #1;
    wr_valid = 1'b0; expv[10] = 32'hAAAA_0005;

    // R6: enable
    @(negedge slow_clk); load_en = 1'b1;
    repeat (20) @(negedge fast_clk);
    check("R6 lk_valid high when enabled and drained", 32'(lk_valid), 32'd1);

    // R1/R2/R5: sweep the table
    for (int i = 0; i < 64; i++) begin
      @(negedge fast_clk); lk_addr = 6'(i); #0.5;
      check((i == 10) ? "R5 last held write wins" : "R1 R2 lookup word", lk_data, expv[i]);
    end

    // R7: collision at address 20
    begin
      logic [31:0] oldv, newv, prev;
      int changes, bad;
      oldv = expv[20]; newv = 32'hC0DE_0020; changes = 0; bad = 0;
      @(negedge fast_clk); lk_addr = 6'd20; #0.5; prev = lk_data;
      fork
        slow_write(6'd20, newv);
        for (int k = 0; k < 40; k++) begin
          @(negedge fast_clk); #0.5;
          if (lk_data !== oldv && lk_data !== newv) bad++;
          if (lk_data !== prev) changes++;
          prev = lk_data;
        end
      join
      check("R7 only old then new seen", 32'(bad), 32'd0);
      check("R7 single transition", 32'(changes), 32'd1);
      check("R7 final word", lk_data, newv);
    end

    // R6: disable
    @(negedge slow_clk); load_en = 1'b0;
    repeat (8) @(negedge fast_clk);
    check("R6 lk_valid falls after load_en low", 32'(lk_valid), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule